// File: doc/BRIEF.md
# Dual-Clock FIFO with Clock-Ratio Timing Modes

This block carries data words from a write clock domain to an unrelated read clock domain. Storage is a small array of flip-flops read through a multiplexer, so no RAM macro is needed. The capacity is odd: 3, 5, 7 or 15 entries. The write and read positions count over the next power-of-two range. Each position crosses to the other domain as a Gray code through a two-flop synchronizer. Each side also has its own reset synchronizer, which asserts the reset at once and releases it on its own clock.

A compile-time parameter tunes the handshake to the clock ratio that is expected.

- **Write-faster setting:** a word is stored on one write edge, and its new write position is published on the next write edge. The reader sees the oldest word directly on its data output and may consume it in the same cycle in which it first sees the word as available.
- **Write-slower setting:** a word and its position are published on the same write edge. The reader detects the available word, pops it, and the word appears on a registered data output from that edge on.

Either setting delivers correct data under any clock ratio. Only throughput depends on the match.

Top module: `xclk_fifo`

## Requirements
- R1: With no reads, the FIFO accepts exactly DEPTH words, after which wr_full reads 1. DEPTH is one of 3, 5, 7 or 15. wr_full returns to 0 once the reader has freed space and that read position has crossed to the write side.
- R2: A write strobe while wr_full is 1 is ignored. The write position does not move, and the offered word is never delivered.
- R3: A read strobe while rd_avail is 0 is ignored. The read position does not move and rd_avail stays 0. In the write-slower setting rd_data also keeps its value.
- R4: Every accepted word is delivered exactly once and in write order. This holds at any ratio of the two clocks and in both settings.
- R5: In the write-faster setting (MODE = XF_WR_FASTER, value 1), rd_data shows the oldest stored word whenever rd_avail is 1. A read edge with rd_en and rd_avail both 1 consumes that word. While rd_avail is 1 and rd_en is 0, rd_avail and rd_data hold.
- R6: In the write-slower setting (MODE = XF_WR_SLOWER, value 0), a read edge with rd_en and rd_avail both 1 loads the oldest word into the rd_data register. rd_data then shows that word from that edge until the next such edge.
- R7: Positions cross between the domains as Gray codes, and each published code changes in at most one bit per clock of its own domain. In the write-faster setting the write position is published one write clock after the storing edge. In the write-slower setting it is published on the storing edge itself.
- R8: While wr_arst_n is 0, wr_full is 0. While rd_arst_n is 0, rd_avail is 0, and in the write-slower setting rd_data is 0. After release, both flags stay 0 until a word is written.
- R9: Storage slots are addressed only in the range 0 to DEPTH-1. The occupancy seen by the write side never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write domain clock |
| wr_arst_n | input | 1 | Write domain reset, active low, asserts asynchronously and is synchronized internally |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No free entry; writes are ignored |
| rd_clk | input | 1 | Read domain clock |
| rd_arst_n | input | 1 | Read domain reset, active low, asserts asynchronously and is synchronized internally |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Oldest word (write-faster setting) or the last popped word (write-slower setting) |
| rd_avail | output | 1 | At least one word is visible to the reader |

## Verification
The bound checker watches, on every clock of each domain:
- that a write while full and a read while empty leave their positions still;
- that each published Gray code moves by at most one bit;
- that slot indices and the writer's occupancy stay within DEPTH;
- that rd_avail and rd_data hold while the reader waits.

Only the bench scenarios can show the end-to-end behaviour. These cover exact delivery order across three read/write clock ratios in both settings, rejected words never reappearing, the exact fill count at which wr_full rises, and the reset values.

// File: rtl/xf_pkg.sv
`timescale 1ns/1ps
package xf_pkg;
  // Handshake timing setting, chosen for the expected clock ratio.
  typedef enum logic {
    XF_WR_SLOWER = 1'b0,
    XF_WR_FASTER = 1'b1
  } xf_mode_e;

  function automatic bit xf_depth_ok(input int d);
    return (d == 3) || (d == 5) || (d == 7) || (d == 15);
  endfunction
endpackage

// File: rtl/xf_rst_sync.sv
`timescale 1ns/1ps
// Asserts at once, releases after two clocks of the local domain.
module xf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb stg_d = {stg_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign rst_n = stg_q[1];
endmodule

// File: rtl/xf_ptr_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a Gray-coded position.
module xf_ptr_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] gray_out
);
  logic [W-1:0] meta_q, safe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      safe_q <= '0;
    end else begin
      meta_q <= gray_in;
      safe_q <= meta_q;
    end
  end

  assign gray_out = safe_q;
endmodule

// File: rtl/xf_wr_side.sv
`timescale 1ns/1ps
// Write position, slot address, full flag and Gray publication.
module xf_wr_side #(
  parameter int DEPTH    = 7,
  parameter int PW       = 3,
  parameter int AW       = 3,
  parameter bit PUB_LATE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] rgray_s,
  output logic          full,
  output logic          push,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wbin,
  output logic [PW-1:0] wgray,
  output logic [PW-1:0] rbin_s
);
  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d, occ;
  logic [AW-1:0] waddr_q, waddr_d;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  always_comb begin
    occ     = wbin_q - rbin_s;
    full    = (occ == PW'(DEPTH));
    push    = wr_en & ~full;
    wbin_d  = push ? wbin_q + 1'b1 : wbin_q;
    waddr_d = waddr_q;
    if (push) waddr_d = (waddr_q == AW'(DEPTH - 1)) ? '0 : waddr_q + 1'b1;
  end

  if (PUB_LATE) begin : g_pub_late
    always_comb wgray_d = wbin_q ^ (wbin_q >> 1);
  end else begin : g_pub_now
    always_comb wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      waddr_q <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      waddr_q <= waddr_d;
      wgray_q <= wgray_d;
    end
  end

  assign waddr = waddr_q;
  assign wbin  = wbin_q;
  assign wgray = wgray_q;
endmodule

// File: rtl/xf_rd_side.sv
`timescale 1ns/1ps
// Read position, slot address, availability and Gray publication.
module xf_rd_side #(
  parameter int DEPTH = 7,
  parameter int PW    = 3,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [PW-1:0] wgray_s,
  output logic          avail,
  output logic          pop,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rbin,
  output logic [PW-1:0] rgray
);
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d, wbin_s;
  logic [AW-1:0] raddr_q, raddr_d;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  always_comb begin
    avail   = (wbin_s != rbin_q);
    pop     = rd_en & avail;
    rbin_d  = pop ? rbin_q + 1'b1 : rbin_q;
    rgray_d = rbin_d ^ (rbin_d >> 1);
    raddr_d = raddr_q;
    if (pop) raddr_d = (raddr_q == AW'(DEPTH - 1)) ? '0 : raddr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      raddr_q <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      raddr_q <= raddr_d;
      rgray_q <= rgray_d;
    end
  end

  assign raddr = raddr_q;
  assign rbin  = rbin_q;
  assign rgray = rgray_q;
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo #(
  parameter int               DATA_W = 16,
  parameter int               DEPTH  = 7,
  parameter xf_pkg::xf_mode_e MODE   = xf_pkg::XF_WR_FASTER
) (
  input  logic              wr_clk,
  input  logic              wr_arst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_arst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_avail
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  logic          wr_rst_sn, rd_rst_sn;
  logic          w_push, r_pop;
  logic [AW-1:0] w_addr, r_addr;
  logic [PW-1:0] w_bin, w_gray, w_rbin_s, r_bin, r_gray;
  logic [PW-1:0] rgray_at_wr, wgray_at_rd;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] head;

  xf_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(wr_arst_n), .rst_n(wr_rst_sn));
  xf_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rd_arst_n), .rst_n(rd_rst_sn));

  xf_ptr_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_sn), .gray_in(r_gray), .gray_out(rgray_at_wr));
  xf_ptr_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_sn), .gray_in(w_gray), .gray_out(wgray_at_rd));

  xf_wr_side #(.DEPTH(DEPTH), .PW(PW), .AW(AW),
               .PUB_LATE(MODE == xf_pkg::XF_WR_FASTER)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_sn), .wr_en(wr_en), .rgray_s(rgray_at_wr),
    .full(wr_full), .push(w_push), .waddr(w_addr), .wbin(w_bin),
    .wgray(w_gray), .rbin_s(w_rbin_s));

  xf_rd_side #(.DEPTH(DEPTH), .PW(PW), .AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_sn), .rd_en(rd_en), .wgray_s(wgray_at_rd),
    .avail(rd_avail), .pop(r_pop), .raddr(r_addr), .rbin(r_bin),
    .rgray(r_gray));

  // Flop storage, written only by the write domain; no reset needed.
  always_ff @(posedge wr_clk) begin
    if (w_push) mem_q[w_addr] <= wr_data;
  end

  assign head = mem_q[r_addr];

  if (MODE == xf_pkg::XF_WR_FASTER) begin : g_rd_direct
    assign rd_data = head;
  end else begin : g_rd_reg
    logic [DATA_W-1:0] rdata_q, rdata_d;
    always_comb rdata_d = r_pop ? head : rdata_q;
    always_ff @(posedge rd_clk or negedge rd_rst_sn) begin
      if (!rd_rst_sn) rdata_q <= '0;
      else            rdata_q <= rdata_d;
    end
    assign rd_data = rdata_q;
  end
endmodule

// File: rtl/xclk_fifo_chk.sv
`timescale 1ns/1ps
module xclk_fifo_chk #(
  parameter int               DATA_W = 16,
  parameter int               DEPTH  = 7,
  parameter int               PW     = 3,
  parameter int               AW     = 3,
  parameter xf_pkg::xf_mode_e MODE   = xf_pkg::XF_WR_FASTER
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              wr_rst_sn,
  input logic              rd_rst_sn,
  input logic              wr_en,
  input logic              wr_full,
  input logic              rd_en,
  input logic              rd_avail,
  input logic [DATA_W-1:0] rd_data,
  input logic [PW-1:0]     w_bin,
  input logic [PW-1:0]     w_gray,
  input logic [PW-1:0]     w_rbin_s,
  input logic [PW-1:0]     r_bin,
  input logic [PW-1:0]     r_gray,
  input logic [AW-1:0]     w_addr,
  input logic [AW-1:0]     r_addr
);
  logic [PW-1:0] occ_w;
  assign occ_w = w_bin - w_rbin_s;

  AST_FULL_WRITE_IGNORED: assert property (@(posedge wr_clk) disable iff (!wr_rst_sn)
    (wr_en && wr_full) |=> (w_bin == $past(w_bin))) else $error("write accepted while full"); // R2
  AST_EMPTY_READ_IGNORED: assert property (@(posedge rd_clk) disable iff (!rd_rst_sn)
    (rd_en && !rd_avail) |=> (r_bin == $past(r_bin))) else $error("read accepted while empty"); // R3
  AST_WGRAY_ONE_STEP: assert property (@(posedge wr_clk) disable iff (!wr_rst_sn)
    $countones(w_gray ^ $past(w_gray)) <= 1) else $error("write code jumped"); // R7
  AST_RGRAY_ONE_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_sn)
    $countones(r_gray ^ $past(r_gray)) <= 1) else $error("read code jumped"); // R7
  AST_OCC_BOUND: assert property (@(posedge wr_clk) disable iff (!wr_rst_sn)
    occ_w <= PW'(DEPTH)) else $error("occupancy over capacity"); // R9
  AST_WADDR_RANGE: assert property (@(posedge wr_clk) disable iff (!wr_rst_sn)
    w_addr < AW'(DEPTH)) else $error("write slot out of range"); // R9
  AST_RADDR_RANGE: assert property (@(posedge rd_clk) disable iff (!rd_rst_sn)
    r_addr < AW'(DEPTH)) else $error("read slot out of range"); // R9
  AST_WAIT_HOLDS: assert property (@(posedge rd_clk) disable iff (!rd_rst_sn)
    (rd_avail && !rd_en) |=> (rd_avail && $stable(rd_data))) else $error("head moved while waiting"); // R5

  if (MODE == xf_pkg::XF_WR_SLOWER) begin : g_slow_chk
    AST_RDATA_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_sn)
      !(rd_en && rd_avail) |=> $stable(rd_data)) else $error("registered data moved without pop"); // R6
  end
endmodule

bind xclk_fifo xclk_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PW(PW), .AW(AW), .MODE(MODE)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_sn(wr_rst_sn), .rd_rst_sn(rd_rst_sn),
  .wr_en(wr_en), .wr_full(wr_full), .rd_en(rd_en), .rd_avail(rd_avail),
  .rd_data(rd_data), .w_bin(w_bin), .w_gray(w_gray), .w_rbin_s(w_rbin_s),
  .r_bin(r_bin), .r_gray(r_gray), .w_addr(w_addr), .r_addr(r_addr));

// File: tb/xclk_fifo_test.sv
`timescale 1ns/1ps
// One FIFO instance with its own read clock, stimulus and queue model.
module xclk_fifo_lane #(
  parameter int               DEPTH = 7,
  parameter xf_pkg::xf_mode_e MODE  = xf_pkg::XF_WR_FASTER,
  parameter string            TAG   = "lane"
) (
  input  logic wr_clk,
  output int   n_cmp,
  output int   n_bad,
  output logic done
);
  localparam bit FAST = (MODE == xf_pkg::XF_WR_FASTER);

  logic        rd_clk;
  logic        wr_arst_n, rd_arst_n, wr_en, rd_en, wr_full, rd_avail;
  logic [15:0] wr_data, rd_data;
  int          rd_half;
  logic [15:0] model_q[$];
  int          attempt;
  int          accepted;
  bit          wr_busy;
  bit          pend;
  logic [15:0] pend_val;
  logic [15:0] last_val;

  xclk_fifo #(.DATA_W(16), .DEPTH(DEPTH), .MODE(MODE)) uut (
    .wr_clk(wr_clk), .wr_arst_n(wr_arst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .rd_clk(rd_clk), .rd_arst_n(rd_arst_n), .rd_en(rd_en),
    .rd_data(rd_data), .rd_avail(rd_avail));

  initial begin
    rd_half = 5;
    rd_clk  = 1'b0;
    #1;
    forever #(rd_half) rd_clk = ~rd_clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", TAG, req, act, exp);
    end
  endtask

  // Drive at the falling write edge; full is stable until the next rising edge.
  task automatic wr_try(input bit en);
    @(negedge wr_clk);
    wr_en   = en;
    wr_data = attempt[15:0];
    if (en) begin
      if (!wr_full) begin
        model_q.push_back(attempt[15:0]);
        accepted++;
      end
      attempt++;
    end
  endtask

  // One read cycle: compare what the design shows, then choose the strobe.
  task automatic rd_step(input bit en);
    @(negedge rd_clk);
    if (FAST) begin
      if (rd_avail) begin
        check(model_q.size() > 0, "R4 avail without data", 1, 0);
        if (model_q.size() > 0)
          check(rd_data == model_q[0], "R4 R5 R7 R9 head word", int'(rd_data), int'(model_q[0]));
      end
    end else if (pend) begin
      check(rd_data == pend_val, "R4 R6 R7 R9 popped word", int'(rd_data), int'(pend_val));
      pend = 1'b0;
    end
    rd_en = en;
    if (en && rd_avail && model_q.size() > 0) begin
      pend_val = model_q.pop_front();
      last_val = pend_val;
      if (!FAST) pend = 1'b1;
    end
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    wr_arst_n = 1'b0; rd_arst_n = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    attempt = 1; pend = 1'b0; pend_val = '0; last_val = '0;
    repeat (3) @(negedge wr_clk);
    @(negedge rd_clk);
    check(wr_full == 1'b0, "R8 full in reset", int'(wr_full), 0);
    check(rd_avail == 1'b0, "R8 avail in reset", int'(rd_avail), 0);
    if (!FAST) check(rd_data == 16'h0, "R8 data in reset", int'(rd_data), 0);
    wr_arst_n = 1'b1; rd_arst_n = 1'b1;
    repeat (6) @(negedge wr_clk);
    repeat (4) @(negedge rd_clk);
    check(wr_full == 1'b0, "R8 full after release", int'(wr_full), 0);
    check(rd_avail == 1'b0, "R8 avail after release", int'(rd_avail), 0);

    for (int ph = 0; ph < 3; ph++) begin
      rd_half = (ph == 0) ? 5 : (ph == 1) ? 17 : 3;
      repeat (10) @(negedge rd_clk);
      repeat (10) @(negedge wr_clk);
      // Fill with the reader stalled; extra strobes hit a full FIFO.
      accepted = 0;
      for (int i = 0; i < DEPTH + 3; i++) wr_try(1'b1);
      wr_try(1'b0);
      check(accepted == DEPTH, "R1 accepted count", accepted, DEPTH);
      check(wr_full == 1'b1, "R1 R2 full after fill", int'(wr_full), 1);
      repeat (8) @(negedge rd_clk);
      check(rd_avail == 1'b1, "R5 R6 avail after fill", int'(rd_avail), 1);
      // Concurrent traffic with gaps on both sides.
      wr_busy = 1'b1;
      fork
        begin
          for (int i = 0; i < 40; i++) wr_try((i % 3) != 1);
          wr_try(1'b0);
          wr_busy = 1'b0;
        end
        begin
          int k = 0;
          while (wr_busy || model_q.size() > 0 || pend) begin
            rd_step(((k + ph) % 4) != 3);
            k++;
          end
        end
      join
      // Reads against an empty FIFO are ignored.
      for (int i = 0; i < 6; i++) begin
        rd_step(1'b1);
        check(rd_avail == 1'b0, "R3 avail stays low", int'(rd_avail), 0);
        if (!FAST) check(rd_data == last_val, "R3 data holds", int'(rd_data), int'(last_val));
      end
      rd_step(1'b0);
      repeat (8) @(negedge wr_clk);
      check(wr_full == 1'b0, "R1 full clears when drained", int'(wr_full), 0);
    end
    check(model_q.size() == 0, "R4 all delivered", model_q.size(), 0);
    done = 1'b1;
  end
endmodule

module xclk_fifo_test;
  logic wr_clk = 1'b0;
  always #4 wr_clk = ~wr_clk;  // 125 MHz write clock

  int   c_fast, b_fast, c_slow, b_slow;
  logic d_fast, d_slow;

  xclk_fifo_lane #(.DEPTH(7), .MODE(xf_pkg::XF_WR_FASTER), .TAG("wr-faster")) lane_fast (
    .wr_clk(wr_clk), .n_cmp(c_fast), .n_bad(b_fast), .done(d_fast));
  xclk_fifo_lane #(.DEPTH(5), .MODE(xf_pkg::XF_WR_SLOWER), .TAG("wr-slower")) lane_slow (
    .wr_clk(wr_clk), .n_cmp(c_slow), .n_bad(b_slow), .done(d_slow));

  initial begin
    int cyc = 0;
    int total;
    int bad;
    #1;
    while (!(d_fast === 1'b1 && d_slow === 1'b1) && cyc < 100000) begin
      @(posedge wr_clk);
      cyc++;
    end
    total = c_fast + c_slow;
    bad   = b_fast + b_slow;
    if (!(d_fast === 1'b1 && d_slow === 1'b1)) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end
endmodule